// File: doc/BRIEF.md
# Infix to postfix token converter

This block sits between a calculator keypad front end and an evaluator. It takes an expression written in ordinary infix form, one token per handshake, and emits the same expression in postfix order. The token source offers either a signed small operand, with a 4-bit magnitude and a sign bit, or an operator code: add, subtract, AND, OR, an opening bracket, a closing bracket, or the equals terminator. The converter keeps pending operators on an internal stack and releases them when the precedence rules allow. It emits a stream of tagged tokens that an evaluator can consume directly with a value stack.

Add and subtract bind tighter than AND and OR. Operators of the same class group left to right, and brackets override both rules. Reordering never runs as an unrolled loop. Each stack pop, discard or push takes its own clock cycle. While that work is pending, the block raises `busy` and accepts no new token. The equals token drains the stack and produces a one-cycle completion pulse. Malformed input sets a sticky error flag, which only reset clears.

Top module: `postfix_reorder`

## Requirements
- R1: A token is accepted on a rising edge where `busy` is low and `opd_valid` or `opr_valid` is high. An accepted operand, with only `opd_valid` high, appears on the output in the next cycle. In that cycle `out_valid` is 1 and `out_is_op` is 0. In `out_value`, bit 16 is the sign, bits 3:0 are the magnitude and all other bits are 0. `out_valid` is high for exactly one cycle per emitted token.
- R2: An emitted operator has `out_is_op` 1. Bits 4:0 of `out_value` hold its code and bits 16:5 are 0. The codes are add 00000, subtract 00001, AND 00010, OR 00011, opening bracket 00100, closing bracket 00101 and equals 11111.
- R3: An incoming add or subtract first pops and emits stacked operators while the top of the stack is add or subtract, then pushes itself. This gives left-to-right grouping, so 1 - 2 + 3 becomes 1 2 - 3 +.
- R4: An incoming AND or OR first pops and emits stacked operators while the top of the stack is any of add, subtract, AND or OR, then pushes itself.
- R5: An opening bracket is pushed in its accept cycle, with no busy period. A closing bracket pops and emits operators until it reaches an opening bracket. That opening bracket is removed from the stack without being emitted. Bracket codes never appear on the output.
- R6: Equals pops and emits every stacked operator, newest first. When the stack is empty, `done` is high for exactly one cycle. Any opening bracket still on the stack at that point is discarded without being emitted and sets the error flag.
- R7: At most one stack pop or push happens per cycle. After a binary operator, closing bracket or equals is accepted, `busy` is high from the next cycle until that token's stack work is complete. While `busy` is high, no token is accepted.
- R8: A token is ignored, with no output and no stack change, and sets `err` in either of two cases: both strobes are high together, or the operator code is none of the seven listed codes.
- R9: The operator stack holds 16 entries. The error flag is set, and the offending token is dropped, in either of two cases: a push onto a full stack, or a closing bracket that finds no opening bracket.
- R10: After reset, `busy`, `out_valid`, `done` and `err` are 0 and the stack is empty. Once set, `err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opd_valid | input | 1 | Operand token offered |
| opd_mag | input | 4 | Operand magnitude |
| opd_neg | input | 1 | Operand sign (1 = negative) |
| opr_valid | input | 1 | Operator token offered |
| opr_code | input | 5 | Operator code |
| busy | output | 1 | Stack work pending; the block accepts no token |
| out_valid | output | 1 | Output token present this cycle |
| out_is_op | output | 1 | Tag: 0 operand, 1 operator |
| out_value | output | 17 | Widened operand or operator code |
| done | output | 1 | One-cycle pulse when equals has drained the stack |
| err | output | 1 | Sticky error flag |

## Verification
The assertions check the following properties on every cycle:
- The stack is never pushed when full or popped when empty, and never moves twice in a cycle.
- An accepted operand always shows up tagged as an operand in the next cycle.
- Emitted operators carry zero upper bits and never a bracket code.
- `done` is a single-cycle pulse, and `err` never falls.

Precedence ordering, bracket matching, the exact order of the drained operators, and the cases where bad tokens are dropped can only be shown by the bench scenarios. The bench compares the whole output stream against its own model for directed expressions and seeded random ones.

// File: rtl/postfix_pkg.sv
package postfix_pkg;

    localparam int OPD_W  = 4;
    localparam int VAL_W  = 17;
    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t C_ADD   = 5'b00000;
    localparam code_t C_SUB   = 5'b00001;
    localparam code_t C_AND   = 5'b00010;
    localparam code_t C_OR    = 5'b00011;
    localparam code_t C_OPEN  = 5'b00100;
    localparam code_t C_CLOSE = 5'b00101;
    localparam code_t C_EQ    = 5'b11111;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OPER,
        S_CLOSE,
        S_FLUSH
    } state_t;

    typedef struct packed {
        logic             is_op;
        logic [VAL_W-1:0] value;
    } tok_t;

    function automatic logic is_addsub(code_t c);
        return (c == C_ADD) || (c == C_SUB);
    endfunction

    function automatic logic is_logic(code_t c);
        return (c == C_AND) || (c == C_OR);
    endfunction

    function automatic logic is_binop(code_t c);
        return is_addsub(c) || is_logic(c);
    endfunction

    // Does a stacked operator leave before the incoming one is pushed?
    function automatic logic must_pop(code_t incoming, code_t top);
        if (is_addsub(incoming)) begin
            return is_addsub(top);
        end
        return is_binop(top);
    endfunction

    function automatic logic [VAL_W-1:0] widen(logic [OPD_W-1:0] mag, logic neg);
        logic [VAL_W-1:0] v;
        v = '0;
        v[OPD_W-1:0] = mag;
        v[VAL_W-1]   = neg;
        return v;
    endfunction

    function automatic logic [VAL_W-1:0] op_value(code_t c);
        logic [VAL_W-1:0] v;
        v = '0;
        v[CODE_W-1:0] = c;
        return v;
    endfunction

endpackage

// File: rtl/postfix_opstack.sv
module postfix_opstack #(
    parameter int DEPTH = 16,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == PW'(DEPTH));
    assign top   = empty ? '0 : mem[AW'(cnt - 1'b1)];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[AW'(cnt)] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end else if (pop) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R9: a full stack is never pushed
    a_r9_push_not_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R9: an empty stack is never popped
    a_r9_pop_not_empty: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    // R7: one stack move per cycle
    a_r7_one_move: assert property (@(posedge clk) disable iff (rst) !(push && pop));

endmodule

// File: rtl/postfix_ctrl.sv
module postfix_ctrl
    import postfix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             opd_valid,
    input  logic [OPD_W-1:0] opd_mag,
    input  logic             opd_neg,
    input  logic             opr_valid,
    input  code_t            opr_code,
    output logic             busy,
    output logic             out_valid,
    output logic             out_is_op,
    output logic [VAL_W-1:0] out_value,
    output logic             done,
    output logic             err,
    output logic             st_push,
    output logic             st_pop,
    output code_t            st_din,
    input  code_t            st_top,
    input  logic             st_empty,
    input  logic             st_full
);
    state_t state, nstate;
    code_t  pend, npend;
    tok_t   emit_tok, tok_r;
    logic   emit, set_err, fin, accept;

    assign busy   = (state != S_IDLE);
    assign accept = (opd_valid || opr_valid) && (state == S_IDLE);

    always_comb begin
        nstate   = state;
        npend    = pend;
        st_push  = 1'b0;
        st_pop   = 1'b0;
        st_din   = opr_code;
        emit     = 1'b0;
        emit_tok = '0;
        set_err  = 1'b0;
        fin      = 1'b0;
        case (state)
            S_IDLE: begin
                if (accept) begin
                    if (opd_valid && opr_valid) begin
                        set_err = 1'b1;
                    end else if (opd_valid) begin
                        emit     = 1'b1;
                        emit_tok = '{is_op: 1'b0, value: widen(opd_mag, opd_neg)};
                    end else if (is_binop(opr_code)) begin
                        npend  = opr_code;
                        nstate = S_OPER;
                    end else if (opr_code == C_OPEN) begin
                        if (st_full) set_err = 1'b1;
                        else         st_push = 1'b1;
                    end else if (opr_code == C_CLOSE) begin
                        nstate = S_CLOSE;
                    end else if (opr_code == C_EQ) begin
                        nstate = S_FLUSH;
                    end else begin
                        set_err = 1'b1;
                    end
                end
            end
            S_OPER: begin
                if (!st_empty && must_pop(pend, st_top)) begin
                    st_pop   = 1'b1;
                    emit     = 1'b1;
                    emit_tok = '{is_op: 1'b1, value: op_value(st_top)};
                end else begin
                    nstate = S_IDLE;
                    if (st_full) begin
                        set_err = 1'b1;
                    end else begin
                        st_push = 1'b1;
                        st_din  = pend;
                    end
                end
            end
            S_CLOSE: begin
                if (st_empty) begin
                    set_err = 1'b1;
                    nstate  = S_IDLE;
                end else if (st_top == C_OPEN) begin
                    st_pop = 1'b1;
                    nstate = S_IDLE;
                end else begin
                    st_pop   = 1'b1;
                    emit     = 1'b1;
                    emit_tok = '{is_op: 1'b1, value: op_value(st_top)};
                end
            end
            S_FLUSH: begin
                if (st_empty) begin
                    fin    = 1'b1;
                    nstate = S_IDLE;
                end else if (st_top == C_OPEN) begin
                    st_pop  = 1'b1;
                    set_err = 1'b1;
                end else begin
                    st_pop   = 1'b1;
                    emit     = 1'b1;
                    emit_tok = '{is_op: 1'b1, value: op_value(st_top)};
                end
            end
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            pend      <= C_ADD;
            out_valid <= 1'b0;
            tok_r     <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            state     <= nstate;
            pend      <= npend;
            out_valid <= emit;
            tok_r     <= emit_tok;
            done      <= fin;
            err       <= err | set_err;
        end
    end

    assign out_is_op = tok_r.is_op;
    assign out_value = tok_r.value;

    // R1: an accepted lone operand is on the output next cycle, tagged as operand
    a_r1_opd_next: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && opd_valid && !opr_valid) |=> (out_valid && !out_is_op));
    // R2: operator tokens carry only the code field
    a_r2_op_field: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_op) |-> (out_value[VAL_W-1:CODE_W] == '0));
    // R5: brackets never reach the output
    a_r5_no_bracket: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_op) |-> (out_value[CODE_W-1:0] != C_OPEN && out_value[CODE_W-1:0] != C_CLOSE));
    // R6: completion is a single-cycle pulse, seen only when idle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    // R10: the error flag never falls outside reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst) err |=> err);

endmodule

// File: rtl/postfix_reorder.sv
module postfix_reorder
    import postfix_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              opd_valid,
    input  logic [3:0]        opd_mag,
    input  logic              opd_neg,
    input  logic              opr_valid,
    input  logic [4:0]        opr_code,
    output logic              busy,
    output logic              out_valid,
    output logic              out_is_op,
    output logic [16:0]       out_value,
    output logic              done,
    output logic              err
);
    logic  st_push, st_pop, st_empty, st_full;
    code_t st_din, st_top;

    postfix_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .opd_valid (opd_valid),
        .opd_mag   (opd_mag),
        .opd_neg   (opd_neg),
        .opr_valid (opr_valid),
        .opr_code  (opr_code),
        .busy      (busy),
        .out_valid (out_valid),
        .out_is_op (out_is_op),
        .out_value (out_value),
        .done      (done),
        .err       (err),
        .st_push   (st_push),
        .st_pop    (st_pop),
        .st_din    (st_din),
        .st_top    (st_top),
        .st_empty  (st_empty),
        .st_full   (st_full)
    );

    postfix_opstack #(
        .DEPTH (STACK_DEPTH),
        .W     (CODE_W)
    ) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (st_push),
        .pop   (st_pop),
        .din   (st_din),
        .top   (st_top),
        .empty (st_empty),
        .full  (st_full)
    );

endmodule

// File: tb/test_postfix_reorder.sv
`timescale 1ns/1ps
module test_postfix_reorder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        opd_valid = 1'b0;
    logic [3:0]  opd_mag = '0;
    logic        opd_neg = 1'b0;
    logic        opr_valid = 1'b0;
    logic [4:0]  opr_code = '0;
    logic        busy, out_valid, out_is_op, done, err;
    logic [16:0] out_value;

    always #2.5 clk = ~clk;

    postfix_reorder i_postfix_reorder (
        .clk(clk), .rst(rst), .opd_valid(opd_valid), .opd_mag(opd_mag),
        .opd_neg(opd_neg), .opr_valid(opr_valid), .opr_code(opr_code),
        .busy(busy), .out_valid(out_valid), .out_is_op(out_is_op),
        .out_value(out_value), .done(done), .err(err)
    );

    localparam logic [4:0] K_ADD = 5'd0, K_SUB = 5'd1, K_AND = 5'd2, K_OR = 5'd3;
    localparam logic [4:0] K_OPEN = 5'd4, K_CLOSE = 5'd5, K_EQ = 5'h1f;

    int nchecks = 0;
    int nfail   = 0;

    // captured output
    bit          cap_tag [64];
    logic [16:0] cap_val [64];
    int          ncap  = 0;
    int          ndone = 0;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (ncap < 64) begin
                cap_tag[ncap] = out_is_op;
                cap_val[ncap] = out_value;
            end
            ncap = ncap + 1;
        end
        if (!rst && done) ndone = ndone + 1;
    end

    // reference model
    bit          exp_tag [64];
    logic [16:0] exp_val [64];
    int          nexp = 0;
    logic [4:0]  mstk [16];
    int          msp  = 0;
    bit          merr = 0;
    int          mdone = 0;

    function automatic int prec(logic [4:0] c);
        if (c == K_ADD || c == K_SUB) return 2;
        if (c == K_AND || c == K_OR)  return 1;
        return 0;
    endfunction

    task automatic m_emit(bit tag, logic [16:0] v);
        if (nexp < 64) begin
            exp_tag[nexp] = tag;
            exp_val[nexp] = v;
        end
        nexp = nexp + 1;
    endtask

    task automatic m_opr(logic [4:0] c);
        logic [4:0] t;
        if (prec(c) > 0) begin
            while (msp > 0 && prec(mstk[msp-1]) >= prec(c)) begin
                m_emit(1'b1, {12'd0, mstk[msp-1]});
                msp = msp - 1;
            end
            if (msp == 16) merr = 1;
            else begin mstk[msp] = c; msp = msp + 1; end
        end else if (c == K_OPEN) begin
            if (msp == 16) merr = 1;
            else begin mstk[msp] = c; msp = msp + 1; end
        end else if (c == K_CLOSE) begin
            forever begin
                if (msp == 0) begin merr = 1; break; end
                t = mstk[msp-1];
                msp = msp - 1;
                if (t == K_OPEN) break;
                m_emit(1'b1, {12'd0, t});
            end
        end else if (c == K_EQ) begin
            while (msp > 0) begin
                t = mstk[msp-1];
                msp = msp - 1;
                if (t == K_OPEN) merr = 1;
                else m_emit(1'b1, {12'd0, t});
            end
            mdone = mdone + 1;
        end else begin
            merr = 1;
        end
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        nchecks = nchecks + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic send(bit d, bit o, logic [3:0] mag, bit neg, logic [4:0] code);
        @(negedge clk);
        while (busy) @(negedge clk);
        opd_valid = d; opr_valid = o; opd_mag = mag; opd_neg = neg; opr_code = code;
        @(negedge clk);
        opd_valid = 0; opr_valid = 0;
        if (d && o)  merr = 1;
        else if (d)  m_emit(1'b0, {neg, 12'd0, mag});
        else         m_opr(code);
    endtask

    task automatic num(logic [3:0] m); send(1, 0, m, 0, 5'd0); endtask
    task automatic op(logic [4:0] c);  send(0, 1, 4'd0, 0, c); endtask

    task automatic start_scn();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        ncap = 0; ndone = 0; nexp = 0; msp = 0; merr = 0; mdone = 0;
        rst = 0;
        @(negedge clk);
        // R10: state right after reset
        chk(!busy && !out_valid && !done && !err, "R10", "reset outputs",
            {busy, out_valid, done, err}, 0);
    endtask

    task automatic end_scn(string tag);
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(ncap == nexp, tag, "token count", ncap, nexp);
        for (int i = 0; i < nexp && i < ncap && i < 64; i++) begin
            chk(cap_tag[i] == exp_tag[i] && cap_val[i] == exp_val[i], tag, "token",
                int'({cap_tag[i], cap_val[i]}), int'({exp_tag[i], exp_val[i]}));
        end
        chk(err == merr, tag, "err flag", int'(err), int'(merr));
        chk(ndone == mdone, (tag == "R7") ? "R6" : tag, "done pulses", ndone, mdone);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchecks = nchecks + 1;
        nfail   = nfail + 1;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
        $finish;
    end

    initial begin : main
        int unsigned s;
        s = $urandom(32'd20240611);

        // R1 timing and R7 busy, directed
        start_scn();
        @(negedge clk);
        opd_valid = 1; opd_mag = 4'd9; opd_neg = 1;
        @(negedge clk);
        opd_valid = 0;
        m_emit(1'b0, {1'b1, 12'd0, 4'd9});
        chk(out_valid && !out_is_op && out_value == 17'h10009, "R1", "operand next cycle",
            int'({out_valid, out_is_op, out_value}), int'({2'b10, 17'h10009}));
        chk(!busy, "R7", "no busy after operand", int'(busy), 0);
        @(negedge clk);
        chk(!out_valid, "R1", "single-cycle valid", int'(out_valid), 0);
        opr_valid = 1; opr_code = K_ADD;
        @(negedge clk);
        opr_valid = 0;
        m_opr(K_ADD);
        chk(busy, "R7", "busy after operator", int'(busy), 1);
        @(negedge clk);
        chk(!busy, "R7", "busy ends after push", int'(busy), 0);
        op(K_OPEN);
        chk(!busy, "R5", "open bracket has no busy", int'(busy), 0);
        num(4'd2);
        op(K_CLOSE);
        op(K_EQ);
        end_scn("R2");

        // R3 left grouping of add/sub
        start_scn();
        num(1); op(K_SUB); num(2); op(K_ADD); num(3); op(K_EQ);
        end_scn("R3");

        // R4 logic ops yield to everything
        start_scn();
        num(1); op(K_OR); num(2); op(K_ADD); num(3); op(K_AND); num(4); op(K_EQ);
        end_scn("R4");

        // R5 brackets
        start_scn();
        num(4); op(K_ADD); num(5); op(K_AND); num(6); op(K_ADD);
        op(K_OPEN); num(7); op(K_OR); num(1); op(K_CLOSE); op(K_SUB);
        op(K_OPEN); num(4); op(K_AND); num(10); op(K_CLOSE); op(K_EQ);
        end_scn("R5");

        // R8 both strobes ignored
        start_scn();
        num(1); op(K_ADD); send(1, 1, 4'd7, 0, K_SUB); num(2); op(K_EQ);
        end_scn("R8");

        // R8 unknown code ignored, R10 sticky
        start_scn();
        num(3); send(0, 1, 4'd0, 0, 5'b01000); op(K_OR); num(5); op(K_EQ);
        end_scn("R10");

        // R9 unmatched closing bracket
        start_scn();
        num(1); op(K_AND); num(2); op(K_CLOSE); op(K_EQ);
        end_scn("R9");

        // R9 overflow, R6 flush discards leftover openings
        start_scn();
        for (int i = 0; i < 17; i++) op(K_OPEN);
        chk(err, "R9", "overflow flag", int'(err), 1);
        op(K_EQ);
        end_scn("R9");

        // R7 random expressions
        for (int e = 0; e < 30; e++) begin
            int depth, nt;
            start_scn();
            depth = 0;
            nt = 2 + int'($urandom % 8);
            for (int t = 0; t < nt; t++) begin
                if (depth < 5 && ($urandom % 3) == 0) begin op(K_OPEN); depth++; end
                send(1, 0, 4'($urandom), 1'($urandom), 5'd0);
                while (depth > 0 && ($urandom % 3) == 0) begin op(K_CLOSE); depth--; end
                if (t < nt - 1) op(5'($urandom % 4));
            end
            while (depth > 0) begin op(K_CLOSE); depth--; end
            op(K_EQ);
            end_scn("R7");
        end

        $display("%0d/%0d checks passed", nchecks - nfail, nchecks);
        $finish;
    end

endmodule